// File: doc/BRIEF.md
# Erase Suspend and Resume Controller

This controller sits next to a flash erase sequencer and decides when a running sector erase may be paused and later continued. It watches decoded bus writes for the pause and continue command codes. It also watches the operation the sequencer reports: idle, the sector-gathering window that comes before erase begins, active sector erase, whole-chip erase or program. From these it raises a pause request toward the erase engine and a suspended flag for the rest of the device. When a continue command arrives it pulses a restart request.

Two pause paths exist. During the gathering window the pause takes effect on the next clock edge. During an active erase the controller waits for the engine to acknowledge, and it declares the suspended state by itself once a bounded number of cycles has passed. A pause command that arrives during a chip erase or a program is dropped.

While the erase is paused, every sector chosen for erase is frozen as one group. The controller copies the selection bitmap when it accepts the pause. It forwards reads and programs that target any other sector and refuses those that target a frozen sector. The restart request carries the frozen bitmap, so the engine continues on the same set of sectors.

Top module: `erase_suspend_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `suspended`, `susp_req`, `resume_req` and `acc_denied` are 0.
- R2: A write of data 0xB0 while `op_kind` is 1 (gathering window) sets both `suspended` and `susp_req` on that same clock edge, with no wait for the engine.
- R3: A write of 0xB0 while `op_kind` is 2 (active sector erase) sets `susp_req` on that edge but leaves `suspended` low. `suspended` rises on the edge that samples `eng_susp_ack` high.
- R4: If no acknowledge arrives after an active-erase pause request, `suspended` rises exactly `SUSP_LAT` clock edges after the edge that raised `susp_req`.
- R5: A 0xB0 write while `op_kind` is 0 (idle), 3 (chip erase) or 4 (program) changes neither `susp_req` nor `suspended`.
- R6: While suspended, a read (`acc_prog`=0) or a program (`acc_prog`=1) whose `acc_sector` bit is clear in the bitmap copied at pause time is forwarded in the same cycle on `acc_fwd_rd` or `acc_fwd_pg`. Changes to `sel_map` after the pause do not affect this.
- R7: While suspended, an access to a sector whose bit is set in the copied bitmap raises `acc_denied` and is forwarded on neither output.
- R8: A write of 0x30 while suspended clears `suspended` and `susp_req` and pulses `resume_req` high for exactly one cycle. On that cycle `resume_map` equals the bitmap copied at pause time.
- R9: A 0x30 write while not suspended, including while waiting for the acknowledge, produces no `resume_req`.
- R10: While not suspended, every access is forwarded according to `acc_prog`, and `acc_denied` stays 0.
- R11: While suspended, any other write, including a repeated 0xB0, leaves `suspended` and `susp_req` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | A decoded command write is present this cycle |
| cmd_data | input | 8 | Command data byte (0xB0 pause, 0x30 continue) |
| op_kind | input | 3 | Current operation: 0 idle, 1 window, 2 sector erase, 3 chip erase, 4 program |
| sel_map | input | NSEC | Sectors chosen for erase |
| acc_valid | input | 1 | Array access request |
| acc_prog | input | 1 | Access is a program (1) or a read (0) |
| acc_sector | input | SECW | Sector targeted by the access |
| eng_susp_ack | input | 1 | Engine reports that it has paused |
| susp_req | output | 1 | Pause request to the erase engine (level) |
| resume_req | output | 1 | Single-cycle restart request to the engine |
| resume_map | output | NSEC | Frozen sector bitmap for the restart |
| suspended | output | 1 | Erase is paused |
| acc_fwd_rd | output | 1 | Read is passed to the array |
| acc_fwd_pg | output | 1 | Program is passed to the array |
| acc_denied | output | 1 | Access refused because its sector is frozen |

## Verification
The pause command is applied under each of the five operation codes. This separates the immediate window path from the acknowledged active path and from the three cases that must be dropped. The active path is run once with an early acknowledge and once with no acknowledge at all, which tells the engine-driven entry apart from the forced entry at the cycle bound. Accesses while paused cover reads and programs to both frozen and free sectors, and one access follows a change of `sel_map` to show that the copied bitmap is the one that gates it. Continue commands are sent while paused, while idle and while waiting for the acknowledge, so that an accepted restart can be told apart from an ignored one.

// File: rtl/esc_pkg.sv
// Shared definitions for the erase suspend controller.
// Assumes op_kind is encoded by the erase sequencer with the values below.
package esc_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_SE_WINDOW = 3'd1,
        OP_SE_ACTIVE = 3'd2,
        OP_CHIP      = 3'd3,
        OP_PROGRAM   = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SUSP = 2'd2
    } susp_state_e;

    localparam logic [7:0] CODE_PAUSE    = 8'hB0;
    localparam logic [7:0] CODE_CONTINUE = 8'h30;

endpackage

// File: rtl/esc_cmd_decode.sv
// Command qualifier: turns a raw command write plus the current operation
// into pause-on-window, pause-on-active and continue strobes.
// Assumes cmd_data is valid whenever cmd_we is high; no address is involved.
module esc_cmd_decode
    import esc_pkg::*;
(
    input  logic       cmd_we,
    input  logic [7:0] cmd_data,
    input  logic [2:0] op_kind,
    output logic       pause_win,
    output logic       pause_act,
    output logic       cont_hit
);

    op_kind_e op;
    logic     pause_hit;

    // Qualify the pause code by operation; chip erase and program drop it.
    always_comb begin
        op        = op_kind_e'(op_kind);
        pause_hit = cmd_we && (cmd_data == CODE_PAUSE);
        cont_hit  = cmd_we && (cmd_data == CODE_CONTINUE);
        pause_win = pause_hit && (op == OP_SE_WINDOW);
        pause_act = pause_hit && (op == OP_SE_ACTIVE);
    end

endmodule

// File: rtl/esc_susp_fsm.sv
// Pause state machine. Holds the running / waiting / paused state, bounds
// the wait for the engine acknowledge with a cycle counter, copies the erase
// bitmap at pause time and issues the restart pulse.
// Assumes the strobes from esc_cmd_decode are single-cycle qualified inputs.
module esc_susp_fsm
    import esc_pkg::*;
#(
    parameter int NSEC     = 8,
    parameter int SUSP_LAT = 2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pause_win,
    input  logic            pause_act,
    input  logic            cont_hit,
    input  logic            eng_ack,
    input  logic [NSEC-1:0] sel_map,
    output logic            suspended,
    output logic            susp_req,
    output logic            resume_req,
    output logic [NSEC-1:0] hold_map
);

    localparam int CW = $clog2(SUSP_LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(SUSP_LAT - 1);

    susp_state_e      state;
    logic [CW-1:0]    wait_cnt;

    // State, wait counter, request level and restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_RUN;
            wait_cnt   <= '0;
            susp_req   <= 1'b0;
            resume_req <= 1'b0;
            hold_map   <= '0;
        end else begin
            resume_req <= 1'b0;
            case (state)
                ST_RUN: begin
                    wait_cnt <= '0;
                    if (pause_win) begin
                        state    <= ST_SUSP;
                        susp_req <= 1'b1;
                        hold_map <= sel_map;
                    end else if (pause_act) begin
                        state    <= ST_WAIT;
                        susp_req <= 1'b1;
                        hold_map <= sel_map;
                    end
                end
                ST_WAIT: begin
                    if (eng_ack || (wait_cnt == LAST)) begin
                        state    <= ST_SUSP;
                        wait_cnt <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (cont_hit) begin
                        state      <= ST_RUN;
                        susp_req   <= 1'b0;
                        resume_req <= 1'b1;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Suspended flag decoded from the state register.
    always_comb suspended = (state == ST_SUSP);

    assert_window_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && pause_win) |=> suspended);

    assert_ack_enters_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && eng_ack) |=> suspended);

    assert_wait_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> (wait_cnt < CW'(SUSP_LAT)));

    assert_drop_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !pause_win && !pause_act) |=> !susp_req);

    assert_restart_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |=> !resume_req);

    assert_map_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && !cont_hit) |=> ($stable(hold_map) && suspended));

endmodule

// File: rtl/esc_access_gate.sv
// Access filter. While paused, it passes reads and programs only to sectors
// outside the frozen bitmap and flags the rest; otherwise it passes all.
// Assumes acc_sector values at or above NSEC match no frozen sector.
module esc_access_gate #(
    parameter int NSEC = 8,
    parameter int SECW = 3
) (
    input  logic            suspended,
    input  logic [NSEC-1:0] hold_map,
    input  logic            acc_valid,
    input  logic            acc_prog,
    input  logic [SECW-1:0] acc_sector,
    output logic            acc_fwd_rd,
    output logic            acc_fwd_pg,
    output logic            acc_denied
);

    logic [NSEC-1:0] sec_onehot;
    logic            frozen_hit;

    // One decode bit per sector.
    for (genvar s = 0; s < NSEC; s++) begin : g_dec
        assign sec_onehot[s] = (acc_sector == SECW'(s));
    end

    // Forward or refuse the access.
    always_comb begin
        frozen_hit = |(sec_onehot & hold_map);
        acc_denied = acc_valid && suspended && frozen_hit;
        acc_fwd_rd = acc_valid && !acc_prog && !acc_denied;
        acc_fwd_pg = acc_valid &&  acc_prog && !acc_denied;
    end

endmodule

// File: rtl/erase_suspend_ctrl.sv
// Top of the erase suspend and resume controller. It wires the command
// qualifier, the pause state machine and the access filter together.
// Assumes the erase engine answers susp_req with eng_susp_ack and restarts
// on resume_req using resume_map.
module erase_suspend_ctrl #(
    parameter int NSEC     = 8,
    parameter int SUSP_LAT = 2000,
    parameter int SECW     = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [7:0]      cmd_data,
    input  logic [2:0]      op_kind,
    input  logic [NSEC-1:0] sel_map,
    input  logic            acc_valid,
    input  logic            acc_prog,
    input  logic [SECW-1:0] acc_sector,
    input  logic            eng_susp_ack,
    output logic            susp_req,
    output logic            resume_req,
    output logic [NSEC-1:0] resume_map,
    output logic            suspended,
    output logic            acc_fwd_rd,
    output logic            acc_fwd_pg,
    output logic            acc_denied
);

    logic            pause_win;
    logic            pause_act;
    logic            cont_hit;
    logic [NSEC-1:0] hold_map;

    esc_cmd_decode u_dec (
        .cmd_we    (cmd_we),
        .cmd_data  (cmd_data),
        .op_kind   (op_kind),
        .pause_win (pause_win),
        .pause_act (pause_act),
        .cont_hit  (cont_hit)
    );

    esc_susp_fsm #(.NSEC(NSEC), .SUSP_LAT(SUSP_LAT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pause_win  (pause_win),
        .pause_act  (pause_act),
        .cont_hit   (cont_hit),
        .eng_ack    (eng_susp_ack),
        .sel_map    (sel_map),
        .suspended  (suspended),
        .susp_req   (susp_req),
        .resume_req (resume_req),
        .hold_map   (hold_map)
    );

    esc_access_gate #(.NSEC(NSEC), .SECW(SECW)) u_gate (
        .suspended  (suspended),
        .hold_map   (hold_map),
        .acc_valid  (acc_valid),
        .acc_prog   (acc_prog),
        .acc_sector (acc_sector),
        .acc_fwd_rd (acc_fwd_rd),
        .acc_fwd_pg (acc_fwd_pg),
        .acc_denied (acc_denied)
    );

    // Restart bitmap is the copy taken at pause time.
    always_comb resume_map = hold_map;

    assert_frozen_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && suspended && (int'(acc_sector) < NSEC) && hold_map[acc_sector])
        |-> (acc_denied && !acc_fwd_rd && !acc_fwd_pg));

    assert_running_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !suspended |-> !acc_denied);

    assert_paused_implies_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> susp_req);

endmodule

// File: tb/erase_suspend_ctrl_test.sv
// Scoreboard bench: the driver task queues the expected output vector for
// each cycle; the monitor pops and compares after every rising edge.
module erase_suspend_ctrl_test;

    localparam int NSEC = 8;
    localparam int LAT  = 12;
    localparam int SECW = 3;

    localparam logic [5:0] M_ST  = 6'b111000;
    localparam logic [5:0] M_ALL = 6'b111111;

    typedef struct {
        logic [5:0]      m;
        logic [5:0]      v;
        logic            mc;
        logic [NSEC-1:0] mp;
        string           tag;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_we = 1'b0;
    logic [7:0]      cmd_data = '0;
    logic [2:0]      op_kind = '0;
    logic [NSEC-1:0] sel_map = '0;
    logic            acc_valid = 1'b0;
    logic            acc_prog = 1'b0;
    logic [SECW-1:0] acc_sector = '0;
    logic            eng_susp_ack = 1'b0;
    logic            susp_req, resume_req, suspended;
    logic            acc_fwd_rd, acc_fwd_pg, acc_denied;
    logic [NSEC-1:0] resume_map;

    item_t q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    done  = 1'b0;

    erase_suspend_ctrl #(.NSEC(NSEC), .SUSP_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
        .op_kind(op_kind), .sel_map(sel_map), .acc_valid(acc_valid),
        .acc_prog(acc_prog), .acc_sector(acc_sector), .eng_susp_ack(eng_susp_ack),
        .susp_req(susp_req), .resume_req(resume_req), .resume_map(resume_map),
        .suspended(suspended), .acc_fwd_rd(acc_fwd_rd), .acc_fwd_pg(acc_fwd_pg),
        .acc_denied(acc_denied)
    );

    always #5 clk = ~clk;

    task automatic set_in(input logic we, input logic [7:0] d, input logic [2:0] op,
                          input logic av, input logic ap, input logic [SECW-1:0] sec,
                          input logic ack);
        cmd_we = we; cmd_data = d; op_kind = op;
        acc_valid = av; acc_prog = ap; acc_sector = sec; eng_susp_ack = ack;
    endtask

    // Queue one expected vector {suspended,susp_req,resume_req,rd,pg,denied}.
    task automatic tick(input logic [5:0] m, input logic [5:0] v, input logic mc,
                        input logic [NSEC-1:0] mp, input string tag);
        item_t it;
        it.m = m; it.v = v; it.mc = mc; it.mp = mp; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    // Monitor: compare after each edge while inputs are still held.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            logic [5:0] got;
            it  = q.pop_front();
            got = {suspended, susp_req, resume_req, acc_fwd_rd, acc_fwd_pg, acc_denied};
            n_chk++;
            if (((got ^ it.v) & it.m) != 0 || (it.mc && resume_map != it.mp)) begin
                n_bad++;
                $display("FAIL %s: got %b map %h, expected %b map %h (mask %b)",
                         it.tag, got, resume_map, it.v, it.mp, it.m);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        set_in(0, 8'h00, 3'd0, 0, 0, 0, 0);
        tick(M_ALL, 6'b000000, 0, '0, "R1");
        tick(M_ALL, 6'b000000, 0, '0, "R1");
        rst_n = 1'b1;
        tick(M_ALL, 6'b000000, 0, '0, "R1");

        // R2: pause in the gathering window
        sel_map = 8'h05;
        set_in(1, 8'hB0, 3'd1, 0, 0, 0, 0);
        tick(M_ST, 6'b110000, 0, '0, "R2");
        set_in(0, 8'h00, 3'd1, 1, 0, 3'd1, 0);
        tick(M_ALL, 6'b110100, 0, '0, "R6 read free");
        set_in(0, 8'h00, 3'd1, 1, 1, 3'd3, 0);
        tick(M_ALL, 6'b110010, 0, '0, "R6 program free");
        set_in(0, 8'h00, 3'd1, 1, 0, 3'd0, 0);
        tick(M_ALL, 6'b110001, 0, '0, "R7 read frozen");
        set_in(0, 8'h00, 3'd1, 1, 1, 3'd2, 0);
        tick(M_ALL, 6'b110001, 0, '0, "R7 program frozen");
        sel_map = 8'hFF;
        set_in(0, 8'h00, 3'd1, 1, 0, 3'd1, 0);
        tick(M_ALL, 6'b110100, 0, '0, "R6 copied map");
        set_in(1, 8'hFF, 3'd1, 0, 0, 0, 0);
        tick(M_ST, 6'b110000, 0, '0, "R11 other write");
        set_in(1, 8'hB0, 3'd1, 0, 0, 0, 0);
        tick(M_ST, 6'b110000, 0, '0, "R11 repeat pause");
        set_in(1, 8'h30, 3'd1, 0, 0, 0, 0);
        tick(M_ST, 6'b001000, 1, 8'h05, "R8 restart");
        set_in(0, 8'h00, 3'd0, 0, 0, 0, 0);
        tick(M_ST, 6'b000000, 0, '0, "R8 single pulse");
        set_in(0, 8'h00, 3'd0, 1, 0, 3'd0, 0);
        tick(M_ALL, 6'b000100, 0, '0, "R10 running");

        // R3: active erase, engine acknowledges
        sel_map = 8'h30;
        set_in(1, 8'hB0, 3'd2, 0, 0, 0, 0);
        tick(M_ST, 6'b010000, 0, '0, "R3 request");
        set_in(0, 8'h00, 3'd2, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) tick(M_ST, 6'b010000, 0, '0, "R3 waiting");
        set_in(0, 8'h00, 3'd2, 0, 0, 0, 1);
        tick(M_ST, 6'b110000, 0, '0, "R3 acknowledged");
        set_in(0, 8'h00, 3'd2, 1, 1, 3'd4, 0);
        tick(M_ALL, 6'b110001, 0, '0, "R7 frozen group");
        set_in(0, 8'h00, 3'd2, 1, 1, 3'd0, 0);
        tick(M_ALL, 6'b110010, 0, '0, "R6 program free");
        set_in(1, 8'h30, 3'd2, 0, 0, 0, 0);
        tick(M_ST, 6'b001000, 1, 8'h30, "R8 restart");

        // R4: active erase, no acknowledge
        sel_map = 8'h01;
        set_in(1, 8'hB0, 3'd2, 0, 0, 0, 0);
        tick(M_ST, 6'b010000, 0, '0, "R4 request");
        for (int i = 1; i < LAT; i++) begin
            if (i == 2) begin
                set_in(1, 8'h30, 3'd2, 0, 0, 0, 0);
                tick(M_ST, 6'b010000, 0, '0, "R9 continue while waiting");
            end else begin
                set_in(0, 8'h00, 3'd2, 0, 0, 0, 0);
                tick(M_ST, 6'b010000, 0, '0, "R4 still waiting");
            end
        end
        set_in(0, 8'h00, 3'd2, 0, 0, 0, 0);
        tick(M_ST, 6'b110000, 0, '0, "R4 forced at bound");
        set_in(1, 8'h30, 3'd2, 0, 0, 0, 0);
        tick(M_ST, 6'b001000, 1, 8'h01, "R8 restart");

        // R5: pause dropped for idle, chip erase and program
        set_in(1, 8'hB0, 3'd3, 0, 0, 0, 0);
        tick(M_ST, 6'b000000, 0, '0, "R5 chip erase");
        set_in(1, 8'hB0, 3'd4, 0, 0, 0, 0);
        tick(M_ST, 6'b000000, 0, '0, "R5 program");
        set_in(1, 8'hB0, 3'd0, 0, 0, 0, 0);
        tick(M_ST, 6'b000000, 0, '0, "R5 idle");
        set_in(1, 8'h30, 3'd0, 0, 0, 0, 0);
        tick(M_ST, 6'b000000, 0, '0, "R9 continue while running");
        set_in(0, 8'h00, 3'd3, 1, 1, 3'd0, 0);
        tick(M_ALL, 6'b000010, 0, '0, "R10 selected sector while running");

        set_in(0, 8'h00, 3'd0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule